// File: doc/BRIEF.md
# Timer Output Compare with Pin Override

An 8-bit timer with one compare channel and the logic that drives a single output pin. The counter can count up or down. Each clock in which it is running and equals the compare value raises a one-cycle compare hit. A two-bit output mode sets how that hit changes an internal compare-output flop: leave it alone, toggle it, clear it or set it. When the mode is nonzero, the flop's value replaces a general-purpose port data bit on the pin. The pin's output enable always follows a separate direction bit.

Software reaches the block through a plain register port. Writes take one cycle. Reads are combinational from `rd_addr`. A write to the counter blocks compare hits for the next clock, so loading the compare value itself never produces a hit. A force bit in the control register applies the configured action to the flop at once. The output can therefore be preset while the pin is still an input. There is no data stream, so the block has no valid/ready handshake.

Register map (`wr_addr` / `rd_addr`):
- 0 is the counter.
- 1 is the compare value.
- 2 is control:
  - [1:0] output mode
  - [2] count down
  - [3] force (write-only)
  - [4] run
  - [5] compare-output flop (read-only)
- 3 is the port: [0] is the data bit and [1] is the direction bit (1 = output).

Top module: `tmr_ocmp_top`

## Requirements
- R1: After reset, every register reads 0, the compare-output flop is 0, and `cmp_hit`, `pin_o` and `pin_oe` are 0.
- R2: With run=1 and count down=0, the counter advances by one each clock and wraps from 0xFF to 0x00.
- R3: With run=1 and count down=1, the counter decreases by one each clock and wraps from 0x00 to 0xFF.
- R4: `cmp_hit` is 1 in a cycle exactly when run=1, the counter equals the compare value, and the cycle does not directly follow a counter write.
- R5: In the cycle after a counter write, no hit occurs and the flop does not change, even if the written value equals the compare value.
- R6: On a hit, the output mode acts on the flop as follows: 00 leaves it unchanged, 01 toggles it, 10 clears it to 0 and 11 sets it to 1. Without a hit or a force, the flop holds its value.
- R7: A mode written in a control write already governs a hit or force at that same clock edge.
- R8: Writing control bit 3 = 1 applies the action of the written mode to the flop at that edge. It raises no `cmp_hit` and leaves the counter unchanged. Bit 3 reads back as 0. A force and a hit at the same edge apply the action only once.
- R9: If the registered mode is nonzero, the pin data comes from the flop. If the mode is 00, the pin data comes from port bit 0.
- R10: `pin_oe` equals port bit 1. When it is 0, `pin_o` is 0, but the flop can still be read at control bit 5.
- R11: The flop keeps its value when the output mode or the count direction is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data, combinational |
| cmp_hit | output | 1 | Compare hit in the current cycle |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The counter is checked running upward across 0xFF and downward across 0x00, which separates the two wrap directions and the stop value. Compare hits are checked in three ways:
- approached by counting, to confirm the hit;
- by loading the compare value directly, to confirm the one-cycle block;
- against a load one below the compare value, to prove the block lasts only one cycle.

Each of the four output modes is driven through a real hit. Force is checked alone and together with a hit at the same edge, which tells a single toggle from a double one. The pin is observed with both mode-00 and nonzero modes, with the direction bit set and cleared, so the port source, the flop source and output gating can each be told apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OM_OFF = 2'b00,
    OM_TGL = 2'b01,
    OM_CLR = 2'b10,
    OM_SET = 2'b11
  } om_e;

  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_PORT = 2'd3;

  localparam int B_DOWN  = 2;
  localparam int B_FORCE = 3;
  localparam int B_RUN   = 4;
  localparam int B_OC    = 5;
  localparam int B_PDAT  = 0;
  localparam int B_PDIR  = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] TOP = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         down,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_o,
  output logic         blk_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_nx;
  logic         blk_q;

  always_comb begin
    if (down) cnt_nx = (cnt_q == ZERO) ? TOP : cnt_q - ONE;
    else      cnt_nx = (cnt_q == TOP) ? ZERO : cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      blk_q <= 1'b0;
    end else begin
      blk_q <= ld;
      if (ld)       cnt_q <= ld_val;
      else if (run) cnt_q <= cnt_nx;
    end
  end

  assign cnt_o = cnt_q;
  assign blk_o = blk_q;

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && !down && cnt_q == TOP) |=> (cnt_q == ZERO)); // R2
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && down && cnt_q == ZERO) |=> (cnt_q == TOP)); // R3
  AST_LOAD_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (blk_q && cnt_q == $past(ld_val))); // R5
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 8
) (
  input  logic         run,
  input  logic         blk,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         hit
);
  assign hit = run && !blk && (cnt == cmp);
endmodule

// File: rtl/tmr_ocout.sv
module tmr_ocout
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  om_e  mode_eff,
  input  om_e  mode_q,
  input  logic hit,
  input  logic frc,
  input  logic pdat,
  input  logic pdir,
  output logic oc_o,
  output logic pin_o,
  output logic pin_oe
);
  logic oc_q, oc_nx, act;

  assign act = hit | frc;

  always_comb begin
    oc_nx = oc_q;
    if (act) begin
      unique case (mode_eff)
        OM_TGL:  oc_nx = ~oc_q;
        OM_CLR:  oc_nx = 1'b0;
        OM_SET:  oc_nx = 1'b1;
        default: oc_nx = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_nx;
  end

  assign oc_o   = oc_q;
  assign pin_oe = pdir;
  assign pin_o  = pdir & ((mode_q != OM_OFF) ? oc_q : pdat);

  AST_OC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!act || mode_eff == OM_OFF) |=> $stable(oc_q)); // R6
  AST_OC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode_eff == OM_SET) |=> oc_q); // R6
  AST_OC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode_eff == OM_CLR) |=> !oc_q); // R6
  AST_OC_TGL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode_eff == OM_TGL) |=> (oc_q != $past(oc_q))); // R8
endmodule

// File: rtl/tmr_ocmp_top.sv
module tmr_ocmp_top
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] TOP = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         cmp_hit,
  output logic         pin_o,
  output logic         pin_oe
);
  logic [W-1:0] cmp_q, cnt;
  om_e          mode_q, mode_eff;
  logic         down_q, run_q, pdat_q, pdir_q;
  logic         wr_cnt, wr_ctrl, frc, blk, hit, oc;

  assign wr_cnt  = wr_en && (wr_addr == A_CNT);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign frc     = wr_ctrl && wr_data[B_FORCE];
  assign mode_eff = wr_ctrl ? om_e'(wr_data[1:0]) : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= OM_OFF;
      down_q <= 1'b0;
      run_q  <= 1'b0;
      pdat_q <= 1'b0;
      pdir_q <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CMP: cmp_q <= wr_data;
        A_CTRL: begin
          mode_q <= om_e'(wr_data[1:0]);
          down_q <= wr_data[B_DOWN];
          run_q  <= wr_data[B_RUN];
        end
        A_PORT: begin
          pdat_q <= wr_data[B_PDAT];
          pdir_q <= wr_data[B_PDIR];
        end
        default: ;
      endcase
    end
  end

  tmr_counter #(.W(W), .TOP(TOP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .down(down_q),
    .ld(wr_cnt), .ld_val(wr_data), .cnt_o(cnt), .blk_o(blk)
  );

  tmr_match #(.W(W)) u_match (
    .run(run_q), .blk(blk), .cnt(cnt), .cmp(cmp_q), .hit(hit)
  );

  tmr_ocout u_out (
    .clk(clk), .rst_n(rst_n), .mode_eff(mode_eff), .mode_q(mode_q),
    .hit(hit), .frc(frc), .pdat(pdat_q), .pdir(pdir_q),
    .oc_o(oc), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CNT:  rd_data = cnt;
      A_CMP:  rd_data = cmp_q;
      A_CTRL: begin
        rd_data[1:0]   = mode_q;
        rd_data[B_DOWN] = down_q;
        rd_data[B_RUN]  = run_q;
        rd_data[B_OC]   = oc;
      end
      default: begin
        rd_data[B_PDAT] = pdat_q;
        rd_data[B_PDIR] = pdir_q;
      end
    endcase
  end

  assign cmp_hit = hit;

  AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> !cmp_hit); // R5
  AST_FORCE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (frc && !run_q && !wr_cnt) |=> $stable(cnt)); // R8
  AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_o); // R10
endmodule

// File: tb/sim_tmr_ocmp_top.sv
module sim_tmr_ocmp_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       cmp_hit, pin_o, pin_oe;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  tmr_ocmp_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_hit(cmp_hit), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] ctl(input logic run, input logic frc,
                                     input logic dn, input logic [1:0] md);
    return {3'b000, run, frc, dn, md};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rdchk(2'd0, 8'h00, "R1 cnt");
    rdchk(2'd1, 8'h00, "R1 cmp");
    rdchk(2'd2, 8'h00, "R1 ctrl");
    rdchk(2'd3, 8'h00, "R1 port");
    chk("R1 hit", {7'd0, cmp_hit}, 8'd0);
    chk("R1 pin", {6'd0, pin_oe, pin_o}, 8'd0);
  endtask

  task automatic t_up();
    wr(2'd2, ctl(1, 0, 0, 2'b00));
    wr(2'd0, 8'hFD);
    rdchk(2'd0, 8'hFD, "R2 load");
    idle(); rdchk(2'd0, 8'hFE, "R2 inc");
    idle(); rdchk(2'd0, 8'hFF, "R2 inc");
    idle(); rdchk(2'd0, 8'h00, "R2 wrap");
    idle(); rdchk(2'd0, 8'h01, "R2 after wrap");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_down();
    wr(2'd2, ctl(1, 0, 1, 2'b00));
    wr(2'd0, 8'h02);
    idle(); rdchk(2'd0, 8'h01, "R3 dec");
    idle(); rdchk(2'd0, 8'h00, "R3 dec");
    idle(); rdchk(2'd0, 8'hFF, "R3 wrap");
    idle(); rdchk(2'd0, 8'hFE, "R3 after wrap");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_toggle();
    wr(2'd1, 8'h10);
    wr(2'd2, ctl(1, 0, 0, 2'b01));
    wr(2'd0, 8'h0E);
    chk("R4 no hit 0E", {7'd0, cmp_hit}, 8'd0);
    idle(); chk("R4 no hit 0F", {7'd0, cmp_hit}, 8'd0);
    idle(); chk("R4 hit", {7'd0, cmp_hit}, 8'd1);
    idle(); chk("R4 single hit", {7'd0, cmp_hit}, 8'd0);
    rdchk(2'd2, 8'h31, "R6 toggle");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_block();
    wr(2'd1, 8'h20);
    wr(2'd2, ctl(1, 0, 0, 2'b10));
    wr(2'd0, 8'h20);
    chk("R5 blocked", {7'd0, cmp_hit}, 8'd0);
    idle(); rdchk(2'd2, 8'h32, "R5 flop kept");
    wr(2'd0, 8'h1F);
    idle(); chk("R5 block ends", {7'd0, cmp_hit}, 8'd1);
    idle(); rdchk(2'd2, 8'h12, "R6 clear");
    wr(2'd2, ctl(1, 0, 0, 2'b11));
    wr(2'd0, 8'h1F);
    idle(); idle();
    rdchk(2'd2, 8'h33, "R6 set");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_mode_now();
    wr(2'd3, 8'h02);
    chk("R9 port source", {7'd0, pin_o}, 8'd0);
    chk("R10 oe", {7'd0, pin_oe}, 8'd1);
    wr(2'd1, 8'h30);
    wr(2'd2, ctl(1, 0, 0, 2'b00));
    wr(2'd0, 8'h2E);
    idle(); idle();
    chk("R7 hit", {7'd0, cmp_hit}, 8'd1);
    wr(2'd2, ctl(1, 0, 0, 2'b10));
    rdchk(2'd2, 8'h12, "R7 same edge");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_force();
    logic [7:0] c0;
    wr(2'd3, 8'h00);
    rd_addr = 2'd0; #1; c0 = rd_data;
    wr(2'd2, ctl(0, 1, 0, 2'b01));
    rdchk(2'd2, 8'h21, "R8 force applied bit3 reads 0");
    chk("R8 no hit", {7'd0, cmp_hit}, 8'd0);
    rdchk(2'd0, c0, "R8 cnt kept");
    chk("R10 pin gated", {6'd0, pin_oe, pin_o}, 8'd0);
    wr(2'd3, 8'h02);
    chk("R10 pin enabled", {6'd0, pin_oe, pin_o}, 8'd3);
    wr(2'd1, 8'h50);
    wr(2'd2, ctl(1, 0, 0, 2'b01));
    wr(2'd0, 8'h4F);
    idle();
    chk("R8 hit", {7'd0, cmp_hit}, 8'd1);
    wr(2'd2, ctl(1, 1, 0, 2'b01));
    rdchk(2'd2, 8'h11, "R8 force+hit once");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_keep();
    wr(2'd2, ctl(0, 1, 0, 2'b11));
    rdchk(2'd2, 8'h23, "R8 force set");
    wr(2'd2, ctl(0, 0, 1, 2'b00));
    rdchk(2'd2, 8'h24, "R11 kept");
    wr(2'd3, 8'h02);
    chk("R9 mode off uses port", {7'd0, pin_o}, 8'd0);
    wr(2'd1, 8'h60);
    wr(2'd2, ctl(1, 0, 0, 2'b00));
    wr(2'd0, 8'h5F);
    idle();
    chk("R6 off hit", {7'd0, cmp_hit}, 8'd1);
    idle();
    rdchk(2'd2, 8'h30, "R6 off no change");
    wr(2'd2, ctl(0, 0, 0, 2'b01));
    rdchk(2'd2, 8'h21, "R11 kept after mode change");
    chk("R9 flop source", {7'd0, pin_o}, 8'd1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_toggle();
    t_block();
    t_mode_now();
    t_force();
    t_keep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule